// File: doc/BRIEF.md
# Frequency-Locked Loop Digital Controller

This block closes the digital side of a frequency-locked oscillator loop. The block runs on a fast system clock. It receives two pulse streams that are already synchronised to that clock: one pulse for each oscillator edge, and one pulse for each reference period. At every reference tick it counts the oscillator pulses seen since the previous tick and subtracts a programmed multiplication ratio from that count. The signed result steers a coarse control word first. Once the coarse search settles, it steers a fine control word instead. Both words drive an external oscillator DAC.

The coarse search moves one step at a time against the sign of the error. It locks on a zero error or after the step direction has reversed twice in a row. The fine trim then moves one step per measurement. It declares fine lock after two consecutive measurements inside a tolerance band, and that band is looser when quick lock is left enabled. Three further controls shape the loop. Stable mode freezes the fine word once fine lock is reached, while the error keeps being reported. Chill cycles throw away the measurement that straddles a control-word update. An external reference-stop flag makes the loop hold its words, the same as in open loop, until the reference returns.

Top module: `dfll_ctrl`

## Requirements
- R1: At a reference tick (`ref_tick_i`=1, `ref_stop_i`=0), an accepted measurement sets `err_o` to N minus `ratio_i`. N is the number of `osc_pulse_i` high cycles from the cycle after the previous tick up to and including the tick cycle. `err_o` is two's complement and CNT_W+1 bits wide. It is updated on the clock edge that samples the tick, and `err_valid_o` is high for exactly the following cycle.
- R2: While reset is active, and on the edge after any cycle with `enable_i`=0, the outputs take these values: `coarse_o` = 2^(COARSE_W-1), `fine_o` = 2^(FINE_W-1), `err_o` = 0, both lock flags = 0.
- R3: Before coarse lock, each accepted error changes `coarse_o` one edge after `err_valid_o` rises. A positive error decrements `coarse_o` and a negative error increments it, saturating at 0 and at all-ones. Coarse lock is set by a zero error, or by a step whose direction is opposite to the previous step when the previous step was itself a reversal. After coarse lock, `coarse_o` no longer changes.
- R4: `fine_o` stays at its reset value until coarse lock. After that, each accepted nonzero error moves `fine_o` one step against the error's sign, saturating at 0 and at all-ones.
- R5: Fine lock is set when two consecutive accepted measurements taken after coarse lock have |error| <= 1 with `quick_dis_i`=1, or |error| <= 4 with `quick_dis_i`=0.
- R6: While `enable_i` stays high, neither lock flag ever clears, whatever the error or `stable_i` does. `fine_lock_o` is never high while `coarse_lock_o` is low.
- R7: With `stable_i`=1 and fine lock set, `fine_o` does not change, but `err_o` and `err_valid_o` keep reporting every accepted measurement. With `stable_i`=0, fine trimming continues after lock.
- R8: With `chill_dis_i`=0, the first tick after a change of either control word is discarded: `err_o` holds, `err_valid_o` stays low and no word changes. The tick after that one is measured normally. With `chill_dis_i`=1, every tick is measured.
- R9: While `ref_stop_i`=1, ticks are ignored, both words and `err_o` hold and the pulse counter is cleared. The first tick after `ref_stop_i` falls is discarded, and closed-loop operation then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Loop enable; low restarts the search |
| ratio_i | input | CNT_W | Target oscillator pulses per reference period |
| osc_pulse_i | input | 1 | One cycle high per oscillator edge |
| ref_tick_i | input | 1 | One cycle high at the end of each reference period |
| ref_stop_i | input | 1 | Reference-stopped flag from an external detector |
| stable_i | input | 1 | Freeze fine word after fine lock |
| chill_dis_i | input | 1 | Disable discarding of post-update periods |
| quick_dis_i | input | 1 | Use the strict fine-lock tolerance |
| coarse_o | output | COARSE_W | Coarse oscillator control word |
| fine_o | output | FINE_W | Fine oscillator control word |
| err_o | output | CNT_W+1 | Signed ratio error of the last accepted period |
| err_valid_o | output | 1 | Pulse marking a new `err_o` |
| coarse_lock_o | output | 1 | Coarse search finished |
| fine_lock_o | output | 1 | Fine lock reached |

## Verification
The bench builds the block with CNT_W=8, COARSE_W=4 and FINE_W=6. With these widths the reset midpoints are 8 and 32, and the coarse word reaches its all-ones limit of 15 after only seven steps of full negative error, so saturation is inside a short run. Periods of 64 cycles carry up to 63 oscillator pulses, which makes any error from -20 to +10 against a ratio of 20 or 30 an exact, hand-computable value. With these values a closed-loop run with an oscillator whose pulse count is proportional to the control words settles within about ten reference periods, even with chill cycles enabled.

// File: rtl/dfll_pkg.sv
package dfll_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } step_dir_e;
endpackage

// File: rtl/dfll_meas.sv
module dfll_meas #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             osc_pulse_i,
  input  logic             ref_tick_i,
  input  logic             ref_stop_i,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic             chill_arm_i,
  output logic [CNT_W:0]   err_o,
  output logic             stb_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] meas;
  logic             skip_q;

  assign sum  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, osc_pulse_i};
  assign meas = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      skip_q <= 1'b0;
      err_o  <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (!enable_i) begin
        cnt_q  <= '0;
        skip_q <= 1'b0;
        err_o  <= '0;
      end else if (ref_stop_i) begin
        // open-loop hold; partial period after restart is unusable
        cnt_q  <= '0;
        skip_q <= 1'b1;
      end else begin
        if (ref_tick_i) begin
          cnt_q <= '0;
          if (skip_q) begin
            skip_q <= 1'b0;
          end else begin
            err_o <= {1'b0, meas} - {1'b0, ratio_i};
            stb_o <= 1'b1;
          end
        end else begin
          cnt_q <= meas;
        end
        if (chill_arm_i) skip_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfll_coarse.sv
module dfll_coarse
  import dfll_pkg::*;
#(
  parameter int COARSE_W = 5,
  parameter int CNT_W    = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                stb_i,
  input  logic [CNT_W:0]      err_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic                lock_o,
  output logic                upd_o
);
  localparam logic [COARSE_W-1:0] COARSE_INIT = {1'b1, {(COARSE_W-1){1'b0}}};
  localparam logic [COARSE_W-1:0] COARSE_MAX  = {COARSE_W{1'b1}};

  step_dir_e           dir_q, dir_d;
  logic                rev_q, rev_d;
  logic [COARSE_W-1:0] nxt;
  logic                err_zero, err_neg, act, lock_d;

  assign err_zero = (err_i == '0);
  assign err_neg  = err_i[CNT_W];
  assign act      = stb_i && !lock_o && enable_i;

  always_comb begin
    nxt    = coarse_o;
    dir_d  = dir_q;
    rev_d  = rev_q;
    lock_d = 1'b0;
    if (act) begin
      if (err_zero) begin
        lock_d = 1'b1;
      end else begin
        dir_d = err_neg ? DIR_UP : DIR_DN;
        if (err_neg && coarse_o != COARSE_MAX) nxt = coarse_o + 1'b1;
        if (!err_neg && coarse_o != '0)        nxt = coarse_o - 1'b1;
        if (dir_q != DIR_NONE && dir_d != dir_q) begin
          rev_d = 1'b1;
          if (rev_q) lock_d = 1'b1;
        end else begin
          rev_d = 1'b0;
        end
      end
    end
  end

  assign upd_o = act && (nxt != coarse_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_o <= COARSE_INIT;
      dir_q    <= DIR_NONE;
      rev_q    <= 1'b0;
      lock_o   <= 1'b0;
    end else if (!enable_i) begin
      coarse_o <= COARSE_INIT;
      dir_q    <= DIR_NONE;
      rev_q    <= 1'b0;
      lock_o   <= 1'b0;
    end else begin
      coarse_o <= nxt;
      dir_q    <= dir_d;
      rev_q    <= rev_d;
      if (lock_d) lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dfll_fine.sv
module dfll_fine #(
  parameter int FINE_W     = 8,
  parameter int CNT_W      = 10,
  parameter int TOL_STRICT = 1,
  parameter int TOL_QUICK  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              active_i,
  input  logic              stb_i,
  input  logic [CNT_W:0]    err_i,
  input  logic              stable_i,
  input  logic              quick_dis_i,
  output logic [FINE_W-1:0] fine_o,
  output logic              lock_o,
  output logic              upd_o
);
  localparam logic [FINE_W-1:0] FINE_INIT = {1'b1, {(FINE_W-1){1'b0}}};
  localparam logic [FINE_W-1:0] FINE_MAX  = {FINE_W{1'b1}};
  localparam logic [CNT_W:0]    TOL_S     = (CNT_W+1)'(TOL_STRICT);
  localparam logic [CNT_W:0]    TOL_Q     = (CNT_W+1)'(TOL_QUICK);

  logic [CNT_W:0]    mag, tol;
  logic              in_tol, act, frozen, hit_q;
  logic [FINE_W-1:0] nxt;

  assign mag    = err_i[CNT_W] ? (~err_i + 1'b1) : err_i;
  assign tol    = quick_dis_i ? TOL_S : TOL_Q;
  assign in_tol = (mag <= tol);
  assign act    = stb_i && active_i && enable_i;
  assign frozen = stable_i && lock_o;

  always_comb begin
    nxt = fine_o;
    if (act && !frozen && err_i != '0) begin
      if (err_i[CNT_W] && fine_o != FINE_MAX) nxt = fine_o + 1'b1;
      if (!err_i[CNT_W] && fine_o != '0)      nxt = fine_o - 1'b1;
    end
  end

  assign upd_o = act && (nxt != fine_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_o <= FINE_INIT;
      hit_q  <= 1'b0;
      lock_o <= 1'b0;
    end else if (!enable_i) begin
      fine_o <= FINE_INIT;
      hit_q  <= 1'b0;
      lock_o <= 1'b0;
    end else begin
      fine_o <= nxt;
      if (act) begin
        hit_q <= in_tol;
        if (in_tol && hit_q) lock_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfll_ctrl.sv
module dfll_ctrl #(
  parameter int CNT_W      = 10,
  parameter int COARSE_W   = 5,
  parameter int FINE_W     = 8,
  parameter int TOL_STRICT = 1,
  parameter int TOL_QUICK  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [CNT_W-1:0]    ratio_i,
  input  logic                osc_pulse_i,
  input  logic                ref_tick_i,
  input  logic                ref_stop_i,
  input  logic                stable_i,
  input  logic                chill_dis_i,
  input  logic                quick_dis_i,
  output logic [COARSE_W-1:0] coarse_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic [CNT_W:0]      err_o,
  output logic                err_valid_o,
  output logic                coarse_lock_o,
  output logic                fine_lock_o
);
  logic coarse_upd, fine_upd, chill_arm;

  assign chill_arm = !chill_dis_i && (coarse_upd || fine_upd);

  dfll_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i, .rst_ni, .enable_i, .osc_pulse_i, .ref_tick_i, .ref_stop_i,
    .ratio_i, .chill_arm_i(chill_arm), .err_o, .stb_o(err_valid_o)
  );

  dfll_coarse #(.COARSE_W(COARSE_W), .CNT_W(CNT_W)) u_coarse (
    .clk_i, .rst_ni, .enable_i, .stb_i(err_valid_o), .err_i(err_o),
    .coarse_o, .lock_o(coarse_lock_o), .upd_o(coarse_upd)
  );

  dfll_fine #(
    .FINE_W(FINE_W), .CNT_W(CNT_W),
    .TOL_STRICT(TOL_STRICT), .TOL_QUICK(TOL_QUICK)
  ) u_fine (
    .clk_i, .rst_ni, .enable_i, .active_i(coarse_lock_o),
    .stb_i(err_valid_o), .err_i(err_o), .stable_i, .quick_dis_i,
    .fine_o, .lock_o(fine_lock_o), .upd_o(fine_upd)
  );
endmodule

// File: rtl/dfll_ctrl_chk.sv
module dfll_ctrl_chk #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic                ref_stop_i,
  input logic                stable_i,
  input logic                err_valid_o,
  input logic [COARSE_W-1:0] coarse_o,
  input logic [FINE_W-1:0]   fine_o,
  input logic                coarse_lock_o,
  input logic                fine_lock_o
);
  localparam logic [FINE_W-1:0] FINE_MID = {1'b1, {(FINE_W-1){1'b0}}};

  a_r7_fine_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i) && $past(stable_i) && $past(fine_lock_o)) |-> $stable(fine_o));

  a_r6_coarse_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(coarse_lock_o) |-> !$past(enable_i));

  a_r6_fine_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fine_lock_o) |-> !$past(enable_i));

  a_r6_lock_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_lock_o |-> coarse_lock_o);

  a_r3_coarse_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i) && $past(coarse_lock_o)) |-> $stable(coarse_o));

  a_r4_fine_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coarse_lock_o |-> (fine_o == FINE_MID));

  a_r9_no_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_stop_i |=> !err_valid_o);

  a_r9_words_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i) && $past(ref_stop_i) && $past(ref_stop_i, 2))
      |-> ($stable(coarse_o) && $stable(fine_o)));
endmodule

bind dfll_ctrl dfll_ctrl_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (.*);

// File: tb/sim_dfll_ctrl.sv
module sim_dfll_ctrl;
  localparam int CNT_W = 8;
  localparam int CW    = 4;
  localparam int FW    = 6;
  localparam int PLEN  = 64;
  localparam int NV    = 7;
  // pulses, err, coarse, fine, coarse_lock, fine_lock (ratio 20, strict, no chill)
  localparam int VEC [NV][6] = '{
    '{25,  5, 7, 32, 0, 0},
    '{15, -5, 8, 32, 0, 0},
    '{23,  3, 7, 32, 1, 0},
    '{23,  3, 7, 31, 1, 0},
    '{21,  1, 7, 30, 1, 0},
    '{19, -1, 7, 31, 1, 1},
    '{30, 10, 7, 30, 1, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [CNT_W-1:0] ratio = 8'd20;
  logic osc = 1'b0, tick = 1'b0, stop = 1'b0;
  logic stable = 1'b0, chill_dis = 1'b1, quick_dis = 1'b1;
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;
  logic [CNT_W:0] err;
  logic vld, clk_lock, f_lock, vseen;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dfll_ctrl #(.CNT_W(CNT_W), .COARSE_W(CW), .FINE_W(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .ratio_i(ratio),
    .osc_pulse_i(osc), .ref_tick_i(tick), .ref_stop_i(stop),
    .stable_i(stable), .chill_dis_i(chill_dis), .quick_dis_i(quick_dis),
    .coarse_o(coarse), .fine_o(fine), .err_o(err), .err_valid_o(vld),
    .coarse_lock_o(clk_lock), .fine_lock_o(f_lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int serr();
    return int'($signed(err));
  endfunction

  task automatic period(input int n);
    for (int i = 0; i < PLEN; i++) begin
      @(negedge clk);
      osc  = (i < n);
      tick = (i == PLEN - 1);
    end
    @(negedge clk);
    osc = 1'b0; tick = 1'b0;
    vseen = vld;
    @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 coarse", int'(coarse), 8);
    chk("R2 fine", int'(fine), 32);
    chk("R2 err", serr(), 0);
    chk("R2 locks", int'({clk_lock, f_lock}), 0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5: table walk
    for (int v = 0; v < NV; v++) begin
      period(VEC[v][0]);
      chk("R1 err", serr(), VEC[v][1]);
      chk("R1 valid", int'(vseen), 1);
      chk("R3 coarse", int'(coarse), VEC[v][2]);
      chk("R4 fine", int'(fine), VEC[v][3]);
      chk("R3 coarse_lock", int'(clk_lock), VEC[v][4]);
      chk("R5 fine_lock", int'(f_lock), VEC[v][5]);
    end

    // R7 stable mode freezes fine, error still reported
    stable = 1'b1;
    period(25);
    chk("R7 err", serr(), 5);
    chk("R7 valid", int'(vseen), 1);
    chk("R7 fine frozen", int'(fine), 30);
    chk("R6 locks kept", int'({clk_lock, f_lock}), 3);
    stable = 1'b0;
    period(25);
    chk("R7 fine resumes", int'(fine), 29);
    chk("R6 locks kept", int'({clk_lock, f_lock}), 3);

    // R9 reference stopped
    stop = 1'b1;
    period(30);
    chk("R9 no valid", int'(vseen), 0);
    chk("R9 err held", serr(), 5);
    chk("R9 fine held", int'(fine), 29);
    stop = 1'b0;
    period(30);
    chk("R9 first discarded", int'(vseen), 0);
    chk("R9 fine held", int'(fine), 29);
    period(30);
    chk("R9 resumed err", serr(), 10);
    chk("R9 resumed fine", int'(fine), 28);

    // R2 enable restart, R8 chill cycles
    chill_dis = 1'b0;
    restart();
    chk("R2 coarse", int'(coarse), 8);
    chk("R2 fine", int'(fine), 32);
    chk("R2 err", serr(), 0);
    chk("R2 locks", int'({clk_lock, f_lock}), 0);
    period(25);
    chk("R8 first step", int'(coarse), 7);
    period(25);
    chk("R8 discarded valid", int'(vseen), 0);
    chk("R8 discarded coarse", int'(coarse), 7);
    period(25);
    chk("R8 next measured", int'(vseen), 1);
    chk("R8 next coarse", int'(coarse), 6);

    // R5 quick lock tolerance
    chill_dis = 1'b1; quick_dis = 1'b0;
    restart();
    period(20);
    chk("R3 zero-error lock", int'(clk_lock), 1);
    chk("R3 coarse kept", int'(coarse), 8);
    period(24);
    chk("R5 quick fine", int'(fine), 31);
    chk("R5 quick not yet", int'(f_lock), 0);
    period(17);
    chk("R5 quick lock", int'(f_lock), 1);
    chk("R5 quick fine", int'(fine), 32);

    // R3 saturation at all-ones
    quick_dis = 1'b1;
    restart();
    for (int k = 0; k < 9; k++) period(0);
    chk("R3 saturated coarse", int'(coarse), 15);
    chk("R3 no lock", int'(clk_lock), 0);
    chk("R1 err negative", serr(), -20);

    // R4 R5 closed loop: oscillator pulses = 3*coarse + fine/8
    chill_dis = 1'b0; quick_dis = 1'b0; ratio = 8'd30;
    restart();
    for (int k = 0; k < 40 && !f_lock; k++) begin
      int n;
      n = 3 * int'(coarse) + int'(fine) / 8;
      if (n > PLEN - 1) n = PLEN - 1;
      period(n);
    end
    chk("R5 closed loop lock", int'(f_lock), 1);
    chk("R5 closed loop err small", int'(serr() <= 4 && serr() >= -4), 1);
    chk("R3 closed loop coarse", int'(coarse), 9);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule